// File: doc/BRIEF.md
# Vector Shift-Right Narrow-and-Pack Unit

This block is a SIMD datapath stage. It shifts every element of two vector sources right by one immediate, keeps the low half of each shifted element, and packs the two narrowed vectors into one result. The first source is a fresh operand. The second is the value the destination register holds before the operation. Because of this, the unit reads the old destination as a full input and forms every result bit from it and from the fresh operand in a single step. No partial result can ever feed back into the computation.

The vector is split into 128-bit lanes. In each lane the narrowed fresh-operand elements fill the lower 64 bits, in element order. The narrowed old-destination elements from the same lane fill the upper 64 bits, also in element order. Four element sizes are handled: 16, 32, 64 and 128 bits in, each giving half that width out. The shift is either logical (zero fill) or arithmetic (sign fill). The width is either 256 bits (both lanes computed) or 128 bits (the upper lane passes the old destination through unchanged).

Each operation is a single-cycle pulse on `valid_i`. The packed result is registered and appears with `valid_o` on the next clock edge.

Top module: `vec_shr_narrow_pack`

## Requirements
- R1: `esize_i` selects the source element width: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = 128-bit. Each source element yields the low half of its shifted value, truncated with no rounding or saturation.
- R2: The shift amount is `imm_i` modulo the source element width, so only its low 4/5/6/7 bits are used for sizes 0/1/2/3. Higher immediate bits have no effect on the result.
- R3: When `arith_i` = 0 the shift fills with zeros. When `arith_i` = 1 it fills with copies of the element's top bit.
- R4: Within each 128-bit lane, result bits 63:0 hold the narrowed `new_vec_i` elements and bits 127:64 hold the narrowed `old_dst_i` elements of that lane. In both halves, element j of the source goes to output element j.
- R5: For size 3, each whole 128-bit lane of each source is shifted as one value. Its low 64 bits go to lane bits 63:0 (new operand) or 127:64 (old destination).
- R6: When `wide_i` = 1, result bits 255:128 are computed from bits 255:128 of both sources. Lane 0 data has no effect on them.
- R7: When `wide_i` = 0, result bits 255:128 equal `old_dst_i` bits 255:128.
- R8: `valid_o` is `valid_i` delayed by one clock, and `result_o` updates on that same edge. While `valid_i` is low, `result_o` holds its value.
- R9: While `rst_ni` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request, one cycle per operation |
| new_vec_i | input | 256 | Fresh source vector |
| old_dst_i | input | 256 | Prior destination contents, used as the second source |
| imm_i | input | 7 | Shift immediate |
| esize_i | input | 2 | Source element size code |
| arith_i | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| wide_i | input | 1 | 1 = 256-bit operation, 0 = 128-bit operation |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 256 | Packed narrowed result |

## Verification
Every result is due exactly one clock edge after the edge that samples `valid_i`. The bench drives each operation on a falling edge and reads `valid_o` and `result_o` one time unit after the next rising edge, which is that due cycle. It also checks the hold behaviour by dropping `valid_i`, changing all other inputs, and confirming after the following rising edge that the result is unchanged. The sweep covers every immediate value, both shift kinds, both widths and all four sizes, using sign-heavy data patterns, and compares each lane half against an arithmetic model.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    ES_16  = 2'd0,
    ES_32  = 2'd1,
    ES_64  = 2'd2,
    ES_128 = 2'd3
  } esize_e;
endpackage

// File: rtl/snp_narrow.sv
module snp_narrow
  import snp_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int IMM_W  = 7
) (
  input  logic [LANE_W-1:0]   src_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  esize_e              esize_i,
  input  logic                arith_i,
  output logic [LANE_W/2-1:0] nar_o
);
  localparam int HALF_W = LANE_W / 2;
  localparam int NSZ    = $clog2(LANE_W / 16) + 1;

  logic [NSZ-1:0][HALF_W-1:0] cand;

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int EW = 16 << k;
    localparam int NE = LANE_W / EW;
    localparam int SW = $clog2(EW);
    logic [SW-1:0] sh;
    assign sh = imm_i[SW-1:0];  // modulo element width
    for (genvar j = 0; j < NE; j++) begin : g_el
      logic [EW-1:0]        el;
      logic                 fill;
      logic [EW+EW/2-1:0]   ext;
      assign el   = src_i[j*EW +: EW];
      assign fill = arith_i & el[EW-1];
      assign ext  = {{(EW/2){fill}}, el};
      // window select == truncated (shift right by sh)
      assign cand[k][j*(EW/2) +: EW/2] = ext[sh +: EW/2];
    end
  end

  assign nar_o = cand[esize_i];

  always_comb begin
    if (esize_i == ES_128 && arith_i && imm_i == {IMM_W{1'b1}})
      assert_sign_fill_R3: assert (nar_o == {HALF_W{src_i[LANE_W-1]}});
    if (esize_i == ES_16 && !arith_i && imm_i[3:0] == 4'hf)
      assert_zero_fill_R3: assert (nar_o[7:1] == 7'd0 && nar_o[HALF_W-1:HALF_W-7] == 7'd0);
  end
endmodule

// File: rtl/snp_lane.sv
module snp_lane
  import snp_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int IMM_W  = 7
) (
  input  logic [LANE_W-1:0] new_i,
  input  logic [LANE_W-1:0] old_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  esize_e            esize_i,
  input  logic              arith_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int HALF_W = LANE_W / 2;

  logic [HALF_W-1:0] new_nar, old_nar;

  snp_narrow #(.LANE_W(LANE_W), .IMM_W(IMM_W)) u_new (
    .src_i(new_i), .imm_i(imm_i), .esize_i(esize_i), .arith_i(arith_i), .nar_o(new_nar)
  );
  snp_narrow #(.LANE_W(LANE_W), .IMM_W(IMM_W)) u_old (
    .src_i(old_i), .imm_i(imm_i), .esize_i(esize_i), .arith_i(arith_i), .nar_o(old_nar)
  );

  assign lane_o = {old_nar, new_nar};
endmodule

// File: rtl/vec_shr_narrow_pack.sv
module vec_shr_narrow_pack
  import snp_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int LANES  = 2,
  parameter int IMM_W  = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] new_vec_i,
  input  logic [LANES*LANE_W-1:0] old_dst_i,
  input  logic [IMM_W-1:0]        imm_i,
  input  logic [1:0]              esize_i,
  input  logic                    arith_i,
  input  logic                    wide_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] result_o
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int HALF_W = LANE_W / 2;

  esize_e                esize;
  logic [VEC_W-1:0]      res_d;
  logic [VEC_W-1:0]      res_q;
  logic                  valid_q;

  assign esize = esize_e'(esize_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    snp_lane #(.LANE_W(LANE_W), .IMM_W(IMM_W)) u_lane (
      .new_i  (new_vec_i[l*LANE_W +: LANE_W]),
      .old_i  (old_dst_i[l*LANE_W +: LANE_W]),
      .imm_i  (imm_i),
      .esize_i(esize),
      .arith_i(arith_i),
      .lane_o (lane_res)
    );
    if (l == 0) begin : g_base
      assign res_d[LANE_W-1:0] = lane_res;
    end else begin : g_upper
      // narrow mode: upper lanes keep old destination
      assign res_d[l*LANE_W +: LANE_W] = wide_i ? lane_res : old_dst_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  assert_valid_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_upper_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> result_o[VEC_W-1:LANE_W] == $past(old_dst_i[VEC_W-1:LANE_W]));
  assert_imm0_pack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esize_i == 2'd3 && imm_i == '0) |=>
      result_o[LANE_W-1:0] == $past({old_dst_i[HALF_W-1:0], new_vec_i[HALF_W-1:0]}));
endmodule

// File: tb/vec_shr_narrow_pack_tb.sv
`timescale 1ns/1ps
module vec_shr_narrow_pack_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [255:0] new_vec_i = '0;
  logic [255:0] old_dst_i = '0;
  logic [6:0]   imm_i = '0;
  logic [1:0]   esize_i = '0;
  logic         arith_i = 1'b0;
  logic         wide_i = 1'b0;
  logic         valid_o;
  logic [255:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vec_shr_narrow_pack dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .new_vec_i(new_vec_i),
    .old_dst_i(old_dst_i), .imm_i(imm_i), .esize_i(esize_i), .arith_i(arith_i),
    .wide_i(wide_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] ref_narrow(logic [127:0] src, int es, bit ar, logic [6:0] imm);
    int ew, n, sh;
    logic [255:0] mask, e;
    logic [63:0] r;
    ew = 16 << es;
    n = 128 / ew;
    sh = int'(imm) % ew;
    mask = (256'd1 << ew) - 256'd1;
    r = '0;
    for (int j = 0; j < n; j++) begin
      e = (256'(src) >> (j * ew)) & mask;
      if (ar && e[ew-1]) e = e | ~mask;
      e = e >> sh;
      for (int b = 0; b < ew / 2; b++) r[j*(ew/2) + b] = e[b];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] pattern(int sel);
    logic [255:0] v;
    case (sel % 5)
      0: v = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      1: v = {32{8'h80}};
      2: v = {16{16'h8001}};
      3: v = {8{32'hF0F0_5A5A}};
      default: v = {$urandom, $urandom, $urandom, $urandom, {4{32'h7FFF_FFFF}}} ^ {128'd0, {2{64'h8000_0000_0000_0000}}};
    endcase
    return v;
  endfunction

  task automatic run_op(int es, bit ar, bit wd, logic [6:0] imm, int sel);
    logic [255:0] nv, od, held, exp;
    logic [63:0] lo_n, lo_o, hi_n, hi_o;
    @(negedge clk_i);
    nv = pattern(sel);
    od = pattern(sel + 2) ^ {8{$urandom}};
    valid_i = 1'b1; new_vec_i = nv; old_dst_i = od; imm_i = imm;
    esize_i = 2'(es); arith_i = ar; wide_i = wd;
    lo_n = ref_narrow(nv[127:0], es, ar, imm);
    lo_o = ref_narrow(od[127:0], es, ar, imm);
    hi_n = ref_narrow(nv[255:128], es, ar, imm);
    hi_o = ref_narrow(od[255:128], es, ar, imm);
    exp[63:0]   = lo_n;
    exp[127:64] = lo_o;
    exp[255:128] = wd ? {hi_o, hi_n} : od[255:128];
    @(posedge clk_i); #1;
    check("R8 valid_o", 256'(valid_o), 256'd1);
    // R1 R2 R3 R5: new-operand half of lane 0
    check(es == 3 ? "R5 low" : (ar ? "R3 low" : "R1 R2 low"), 256'(result_o[63:0]), 256'(exp[63:0]));
    // R4: old-destination half of lane 0
    check("R4 old half", 256'(result_o[127:64]), 256'(exp[127:64]));
    check(wd ? "R6 upper lane" : "R7 upper pass", 256'(result_o[255:128]), 256'(exp[255:128]));
    if (sel % 16 == 3) begin
      held = result_o;
      @(negedge clk_i);
      valid_i = 1'b0; new_vec_i = ~nv; old_dst_i = ~od; imm_i = ~imm;
      @(posedge clk_i); #1;
      check("R8 hold valid", 256'(valid_o), 256'd0);
      check("R8 hold result", result_o, held);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 reset valid", 256'(valid_o), 256'd0);
    check("R9 reset result", result_o, 256'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    for (int es = 0; es < 4; es++)
      for (int ar = 0; ar < 2; ar++)
        for (int wd = 0; wd < 2; wd++)
          for (int im = 0; im < 128; im++) begin
            run_op(es, bit'(ar), bit'(wd), 7'(im), n);
            n++;
          end
    // R2: immediate with junk high bits equals low-bit immediate
    begin
      logic [255:0] r_a;
      @(negedge clk_i);
      valid_i = 1; new_vec_i = {16{16'hC3A5}}; old_dst_i = {16{16'h1234}};
      esize_i = 2'd0; arith_i = 1; wide_i = 1; imm_i = 7'h05;
      @(posedge clk_i); #1; r_a = result_o;
      @(negedge clk_i); imm_i = 7'h75;
      @(posedge clk_i); #1;
      check("R2 imm high bits ignored", result_o, r_a);
      @(negedge clk_i); valid_i = 0;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule